// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between an 8-bit processor core and the pins of a narrow external memory bus. The low address byte and the data byte share one 8-bit port, split here into an output value, an output enable and an input value. A separate high port carries the upper address byte. The core hands over one request at a time. A request is a code fetch, a data read or a data write, with a 16-bit address. The controller either answers it from on-chip ROM or runs a fixed five-phase external cycle on the pins.

Code and data are separate address spaces. A data access always goes off chip. A code fetch goes to on-chip ROM only when the external-access input is high and the address lies below the ROM size; all other fetches go off chip. On an external cycle the address latch strobe is high while the low address sits on the shared port. The port is then released for one clock before the strobe phase. Code reads use the program-store strobe, data reads use the read strobe and data writes use the write strobe, all active low. A data access can be marked short: only the low address byte and a few page bits on the high port are driven, and the other high-port pins stay free for ordinary I/O.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, and until the first request, ale is 0, psen_n, rd_n and wr_n are 1, ad_oe is 0, hi_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: A code fetch (req_op 0) with ext_access 1 and an address below 1000h is served on chip. rom_en is 1 with rom_addr equal to address bits 11:0 in the first cycle after acceptance. rsp_valid is 1 with rsp_data equal to rom_rdata in the third cycle. ale and all strobes stay inactive throughout.
- R3: A code fetch goes to the external bus when ext_access is 0 (any address) or when the address is 1000h or above.
- R4: Data reads (req_op 1) and data writes (req_op 2) always use the external bus, whatever ext_access is and whatever the address.
- R5: An external cycle runs one phase per clock after acceptance. In cycle 1, ale is 1 with ad_oe 1 and ad_out equal to the low address byte. In cycle 2, ale is 0 and the address is still driven. In cycle 3, all strobes are inactive. In cycle 4, the strobe is active. In cycle 5, all strobes are inactive. req_ready is 0 from cycle 1 to cycle 5 and 1 again in cycle 6.
- R6: In cycle 4, a code fetch drives only psen_n low and a data read drives only rd_n low. No two strobes are ever low together.
- R7: On a write, ad_out equals the write data and ad_oe is 1 in cycles 3, 4 and 5. wr_n is low only in cycle 4.
- R8: On an external read, ad_in is sampled at the clock edge that ends cycle 4. It is returned on rsp_data, with rsp_valid high for one cycle, in cycle 5. A write raises no rsp_valid.
- R9: On a full-address access, hi_oe is FFh and hi_out carries address bits 15:8. On a short data access (req_short 1), hi_oe is 07h and hi_out bits 2:0 carry address bits 10:8. Code fetches ignore req_short.
- R10: On an external read, ad_oe is 0 from cycle 3 through cycle 5, so the shared port is released before the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_access | input | 1 | High: low code addresses come from on-chip ROM |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_op | input | 2 | 0 code fetch, 1 data read, 2 data write, 3 treated as data read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_short | input | 1 | Data access uses a one-byte address plus page bits |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read data |
| rom_en | output | 1 | On-chip ROM read enable |
| rom_addr | output | 12 | On-chip ROM address |
| rom_rdata | input | 8 | On-chip ROM data, one cycle after rom_en |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value |
| hi_out | output | 8 | High address port value |
| hi_oe | output | 8 | High address port per-pin enable |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
Cycles are counted from the clock edge that accepts a request. An external cycle shows its address in cycle 1 and its latch fall in cycle 2. The port is released in cycle 3, the strobe is active in cycle 4, and read data appears in cycle 5 with the controller ready in cycle 6. An on-chip fetch shows rom_en in cycle 1 and returns its data in cycle 3. Each scenario task drives its request half a period before an edge. It then samples at the falling edge of every following cycle and compares against the value due in that exact cycle. The external memory and ROM models in the bench capture the latched address and answer reads in the same cycle the controller would sample them.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    OP_CODE = 2'd0,
    OP_DRD  = 2'd1,
    OP_DWR  = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ROM_RD  = 3'd1,
    PH_ROM_CAP = 3'd2,
    PH_ADDR    = 3'd3,
    PH_HOLD    = 3'd4,
    PH_TURN    = 3'd5,
    PH_STRB    = 3'd6,
    PH_RELS    = 3'd7
  } phase_e;

endpackage

// File: rtl/xbus_route.sv
module xbus_route
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 12
) (
  input  op_e               op,
  input  logic              ext_access,
  input  logic [ADDR_W-1:0] addr,
  output logic              on_chip
);

  generate
    if (ROM_AW >= ADDR_W) begin : g_full_rom
      assign on_chip = (op == OP_CODE) && ext_access;
    end else begin : g_part_rom
      function automatic logic below_rom(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:ROM_AW] == '0;
      endfunction
      assign on_chip = (op == OP_CODE) && ext_access && below_rom(addr);
    end
  endgenerate

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  logic   on_chip,
  output phase_e phase,
  output logic   busy
);

  phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:    if (accept) phase_q <= on_chip ? PH_ROM_RD : PH_ADDR;
        PH_ROM_RD:  phase_q <= PH_ROM_CAP;
        PH_ROM_CAP: phase_q <= PH_IDLE;
        PH_ADDR:    phase_q <= PH_HOLD;
        PH_HOLD:    phase_q <= PH_TURN;
        PH_TURN:    phase_q <= PH_STRB;
        PH_STRB:    phase_q <= PH_RELS;
        PH_RELS:    phase_q <= PH_IDLE;
        default:    phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase = phase_q;
  assign busy  = (phase_q != PH_IDLE);

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 3,
  localparam int HI_W     = ADDR_W - DATA_W
) (
  input  phase_e            phase,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              short_a,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic [HI_W-1:0]   hi_oe,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);

  logic addr_ph, data_ph, ext_ph, is_wr, is_code, short_dat;

  assign is_wr     = (op == OP_DWR);
  assign is_code   = (op == OP_CODE);
  assign short_dat = short_a && !is_code;
  assign addr_ph   = (phase == PH_ADDR) || (phase == PH_HOLD);
  assign data_ph   = (phase == PH_TURN) || (phase == PH_STRB) || (phase == PH_RELS);
  assign ext_ph    = addr_ph || data_ph;

  assign ale    = (phase == PH_ADDR);
  assign ad_oe  = addr_ph || (data_ph && is_wr);
  assign ad_out = addr_ph ? addr[DATA_W-1:0] : wdata;
  assign hi_out = addr[ADDR_W-1:DATA_W];

  assign psen_n = !((phase == PH_STRB) && is_code);
  assign wr_n   = !((phase == PH_STRB) && is_wr);
  assign rd_n   = !((phase == PH_STRB) && !is_code && !is_wr);

  genvar g;
  generate
    for (g = 0; g < HI_W; g++) begin : g_hi_en
      if (g < PAGE_BITS) begin : g_page
        assign hi_oe[g] = ext_ph;
      end else begin : g_upper
        assign hi_oe[g] = ext_ph && !short_dat;
      end
    end
  endgenerate

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int ROM_AW    = 12,
  parameter int PAGE_BITS = 3,
  localparam int HI_W     = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_access,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_short,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rom_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   hi_out,
  output logic [HI_W-1:0]   hi_oe,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);

  op_e               in_op, cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_short;
  logic              in_on_chip, accept, busy;
  logic              cap_rom, cap_ext;
  phase_e            phase;

  assign in_op     = (req_op == 2'd3) ? OP_DRD : op_e'(req_op);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  xbus_route #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_route (
    .op(in_op), .ext_access(ext_access), .addr(req_addr), .on_chip(in_on_chip)
  );

  xbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .on_chip(in_on_chip),
    .phase(phase), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_op    <= OP_CODE;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_short <= 1'b0;
    end else if (accept) begin
      cur_op    <= in_op;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
      cur_short <= req_short;
    end
  end

  // capture events: ROM answer, or rising edge of the read strobe
  assign cap_rom = (phase == PH_ROM_CAP);
  assign cap_ext = (phase == PH_STRB) && (cur_op != OP_DWR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap_rom || cap_ext;
      if (cap_rom)      rsp_data <= rom_rdata;
      else if (cap_ext) rsp_data <= ad_in;
    end
  end

  assign rom_en   = (phase == PH_ROM_RD);
  assign rom_addr = cur_addr[ROM_AW-1:0];

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_pins (
    .phase(phase), .op(cur_op), .addr(cur_addr), .wdata(cur_wdata),
    .short_a(cur_short), .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out),
    .hi_oe(hi_oe), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic rom_en,
  input logic ad_oe,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n
);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  assert_ale_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && psen_n && rd_n && wr_n && !req_ready));

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |=> (psen_n && rd_n && wr_n));

  assert_wr_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);

  assert_rd_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !ad_oe);

  assert_rd_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(psen_n) || $rose(rd_n)) |-> rsp_valid);

  assert_onchip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (!ale && psen_n && rd_n && wr_n));

endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rom_en(rom_en), .ad_oe(ad_oe), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
  .wr_n(wr_n)
);

// File: tb/sim_xbus_ctrl.sv
module sim_xbus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_access = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        req_short = 1'b0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        rom_en;
  logic [11:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic [7:0]  hi_out;
  logic [7:0]  hi_oe;
  logic        ale, psen_n, rd_n, wr_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xbus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_access(ext_access), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_short(req_short), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rom_en(rom_en), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .hi_out(hi_out), .hi_oe(hi_oe), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n)
  );

  // content models, written differently from anything in the design
  function automatic logic [7:0] rom_val(input logic [11:0] a);
    return (a[7:0] + 8'h33) ^ {4'h0, a[11:8]};
  endfunction

  function automatic logic [7:0] ext_code_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // external latch, memory and on-chip ROM models
  logic [7:0] lat_lo = 8'h00;
  logic [7:0] dmem [256];
  logic [7:0] rom_q = 8'h00;

  initial for (int i = 0; i < 256; i++) dmem[i] = 8'h00;

  always @(posedge clk) begin
    if (ale) lat_lo <= ad_out;
    if (!wr_n && ad_oe) dmem[lat_lo] <= ad_out;
    if (rom_en) rom_q <= rom_val(rom_addr);
  end

  assign rom_rdata = rom_q;
  assign ad_in = !psen_n ? ext_code_val({hi_out, lat_lo}) :
                 !rd_n   ? dmem[lat_lo] : 8'hEE;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    check(ale == 1'b0, "R1 ale", ale, 0);
    check({psen_n, rd_n, wr_n} == 3'b111, "R1 strobes", {psen_n, rd_n, wr_n}, 3'b111);
    check(ad_oe == 1'b0 && hi_oe == 8'h00, "R1 port enables", {ad_oe, hi_oe}, 0);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake",
          {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_onchip(input logic [15:0] a);
    @(negedge clk);
    ext_access = 1'b1; req_op = 2'd0; req_addr = a; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;           // cycle 1
    check(rom_en == 1'b1 && rom_addr == a[11:0], "R2 rom request", {rom_en, rom_addr},
          {1'b1, a[11:0]});
    check(ale == 1'b0 && psen_n == 1'b1, "R2 bus quiet", {ale, psen_n}, 2'b01);
    @(negedge clk);                             // cycle 2
    check(rom_en == 1'b0 && rsp_valid == 1'b0, "R2 cycle2", {rom_en, rsp_valid}, 0);
    @(negedge clk);                             // cycle 3
    check(rsp_valid == 1'b1 && rsp_data == rom_val(a[11:0]), "R2 rom data",
          {rsp_valid, rsp_data}, {1'b1, rom_val(a[11:0])});
    check(req_ready == 1'b1 && ale == 1'b0, "R2 idle again", {req_ready, ale}, 2'b10);
  endtask

  // op: 0 code, 1 data read, 2 data write
  task automatic t_ext(input logic [1:0] op, input logic [15:0] a, input logic [7:0] wd,
                       input bit sh, input bit ea, input logic [7:0] exp_rd,
                       input string tag);
    bit wr = (op == 2'd2);
    logic [7:0] mask = (sh && op != 2'd0) ? 8'h07 : 8'hFF;
    @(negedge clk);
    ext_access = ea; req_op = op; req_addr = a; req_wdata = wd; req_short = sh;
    req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;           // cycle 1
    check(ale && ad_oe && ad_out == a[7:0], {tag, " R5 address phase"},
          {ale, ad_oe, ad_out}, {2'b11, a[7:0]});
    check(rom_en == 1'b0 && req_ready == 1'b0, {tag, " R3 R4 external route"},
          {rom_en, req_ready}, 0);
    check(hi_oe == mask && (hi_out & mask) == (a[15:8] & mask), {tag, " R9 high port"},
          {hi_oe, hi_out & mask}, {mask, a[15:8] & mask});
    @(negedge clk);                             // cycle 2
    check(!ale && ad_oe && ad_out == a[7:0], {tag, " R5 latch fall"},
          {ale, ad_oe, ad_out}, {2'b01, a[7:0]});
    @(negedge clk);                             // cycle 3
    check({psen_n, rd_n, wr_n} == 3'b111, {tag, " R5 turnaround"},
          {psen_n, rd_n, wr_n}, 3'b111);
    if (wr) check(ad_oe && ad_out == wd, {tag, " R7 early data"}, {ad_oe, ad_out}, {1'b1, wd});
    else    check(ad_oe == 1'b0, {tag, " R10 released"}, ad_oe, 0);
    @(negedge clk);                             // cycle 4
    check({psen_n, rd_n, wr_n} == ~(3'b100 >> op), {tag, " R6 strobe select"},
          {psen_n, rd_n, wr_n}, ~(3'b100 >> op));
    if (wr) check(ad_oe && ad_out == wd, {tag, " R7 data at strobe"}, {ad_oe, ad_out}, {1'b1, wd});
    else    check(ad_oe == 1'b0, {tag, " R10 released at strobe"}, ad_oe, 0);
    @(negedge clk);                             // cycle 5
    check({psen_n, rd_n, wr_n} == 3'b111, {tag, " R5 release"}, {psen_n, rd_n, wr_n}, 3'b111);
    if (wr) begin
      check(ad_oe && ad_out == wd, {tag, " R7 data hold"}, {ad_oe, ad_out}, {1'b1, wd});
      check(rsp_valid == 1'b0, {tag, " R8 no write response"}, rsp_valid, 0);
    end else begin
      check(rsp_valid && rsp_data == exp_rd, {tag, " R8 read data"},
            {rsp_valid, rsp_data}, {1'b1, exp_rd});
    end
    @(negedge clk);                             // cycle 6
    check(req_ready && !ad_oe && hi_oe == 8'h00 && !rsp_valid, {tag, " R5 ready"},
          {req_ready, ad_oe, hi_oe, rsp_valid}, {1'b1, 1'b0, 8'h00, 1'b0});
  endtask

  initial begin
    #3;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_onchip(16'h0000);
    t_onchip(16'h0FFF);
    t_ext(2'd0, 16'h1000, 8'h00, 1'b0, 1'b1, ext_code_val(16'h1000), "R3 boundary");
    t_ext(2'd0, 16'h0ABC, 8'h00, 1'b0, 1'b0, ext_code_val(16'h0ABC), "R3 ea low");
    t_ext(2'd0, 16'h2345, 8'h00, 1'b1, 1'b1, ext_code_val(16'h2345), "R9 code full");
    t_ext(2'd2, 16'h0055, 8'hA7, 1'b0, 1'b1, 8'h00, "R4 write low addr");
    t_ext(2'd1, 16'h0055, 8'h00, 1'b0, 1'b1, 8'hA7, "R4 read low addr");
    t_ext(2'd2, 16'h0533, 8'h3C, 1'b1, 1'b0, 8'h00, "R9 short write");
    t_ext(2'd1, 16'h0533, 8'h00, 1'b1, 1'b1, 8'h3C, "R9 short read");
    t_ext(2'd1, 16'hFF55, 8'h00, 1'b0, 1'b0, 8'hA7, "R8 read high addr");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule